// File: doc/BRIEF.md
# Byte-Wide Clock-Synchronous Serial Port with Pin-Direction Control

This block moves bytes over a clocked serial link, MSB first. The transmit side is double buffered: a CPU-written holding register feeds a shift register, so a second byte can wait while the first is going out. The receive side lands each finished byte in a holding register for the CPU to read. Four flags are exported both as outputs and in a status register: transmit holding empty, transmit finished, receive holding full and receive overrun. Software never sets these flags. Reading or writing the data registers clears them.

The port runs as clock master or as slave. As master it makes the serial clock from the system clock with a fixed divider. As slave it follows an external serial clock after a two-stage synchronizer. There are three bus layouts: plain synchronous, four-wire, and four-wire with one shared data line. The block decodes the layout, the master bit and the two enable bits into output enables for its three pins. A pin that the current setting does not use is left undriven so it can serve as general I/O.

The CPU port is a small register file with four addresses: control, status, transmit data and receive data. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, transmit-empty and transmit-end read 1, receive-full and overrun read 0, and the output enables for the clock, data-out and data-in pins are all 0.
- R2: If transmit is enabled, writing the transmit data register (address 2) while the shift register is idle moves the byte straight into the shift register. Transmit-empty still reads 1 after that edge, and transmit-end reads 0.
- R3: A write to the transmit data register while a byte is shifting sets transmit-empty to 0. The queued byte is taken when the current byte ends, and its clock pulses follow without further CPU action.
- R4: Bytes shift MSB first, 8 bits each. The master holds its clock low when idle. Each clock half-period lasts CLK_DIV system cycles, and data is valid at every rising clock edge.
- R5: Transmit-end goes to 1 when the last bit of a byte has shifted out and transmit-empty is 1. It stays 0 between the bytes of a queued pair.
- R6: A received byte is stored and receive-full is set at the eighth rising clock edge. Reading the receive data register (address 3) returns that byte and clears receive-full.
- R7: If a byte arrives while receive-full is 1, overrun (status bit 3) is set and the stored byte is kept. Writing the status register (address 1) with bit 3 at 0 clears overrun.
- R8: Writing the status register with bit 0 at 0 clears transmit-empty. Writing bit 0 at 1 has no effect. With transmit enabled, clearing transmit-empty this way sends the byte still held in the transmit data register once more.
- R9: Control register (address 0) bits: [1:0] bus layout (0x plain, 10 four-wire, 11 shared line), [2] master, [3] transmit enable, [4] receive enable. In the plain layout, and in the four-wire layout as master, transmit drives data-out and receive reads data-in.
- R10: In the four-wire layout as slave, the roles swap. Transmit drives the data-in pin and receive reads the data-out pin.
- R11: In the shared-line layout, data-out carries both directions and the data-in pin is never driven. If transmit and receive are both enabled there, transmit wins and no byte is received.
- R12: The clock pin's output enable is 1 only in master mode with transmit or receive enabled. In slave mode the clock is taken from the clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| tx_empty | output | 1 | Transmit holding register empty flag |
| tx_end | output | 1 | Transmission finished flag |
| rx_full | output | 1 | Receive holding register full flag |
| rx_ovr | output | 1 | Receive overrun flag |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdo_i | input | 1 | Data-out pin input side |
| sdo_o | output | 1 | Data-out pin output side |
| sdo_oe | output | 1 | Data-out pin output enable |
| sdi_i | input | 1 | Data-in pin input side |
| sdi_o | output | 1 | Data-in pin output side |
| sdi_oe | output | 1 | Data-in pin output enable |

## Verification
A bad flag update is visible on the flag outputs at the very next edge after the register access. This covers a lost same-edge reload, a missing clear or a wrong overrun. A shift-state error changes the bit pattern or the clock spacing within one serial clock period. A pin-decode error shows on the enables as soon as the control write lands, or as a byte read from the wrong pin. It also shows as a byte received in the shared-line layout when none should be.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    LAYOUT_PLAIN0 = 2'b00,
    LAYOUT_PLAIN1 = 2'b01,
    LAYOUT_FOUR   = 2'b10,
    LAYOUT_SHARED = 2'b11
  } layout_e;

  typedef struct packed {
    logic    rx_en;
    logic    tx_en;
    logic    master;
    layout_e layout;
  } ctrl_t;

  localparam int unsigned CTRL_W   = 5;
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;
  localparam int unsigned REG_TXD  = 2;
  localparam int unsigned REG_RXD  = 3;
  localparam int unsigned ST_TXE   = 0;
  localparam int unsigned ST_TEND  = 1;
  localparam int unsigned ST_RXF   = 2;
  localparam int unsigned ST_OVR   = 3;
endpackage

// File: rtl/ssu_pin_map.sv
module ssu_pin_map
  import ssu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  output logic  tx_act,
  output logic  rx_act,
  output logic  rx_from_sdo,
  output logic  sck_oe,
  output logic  sdo_oe,
  output logic  sdi_oe
);
  logic shared_line;
  logic swapped;

  assign shared_line = (ctrl.layout == LAYOUT_SHARED);
  assign swapped     = (ctrl.layout == LAYOUT_FOUR) && !ctrl.master;

  assign tx_act      = ctrl.tx_en;
  assign rx_act      = ctrl.rx_en && !(shared_line && ctrl.tx_en);
  assign rx_from_sdo = shared_line || swapped;

  assign sdo_oe = tx_act && !swapped;
  assign sdi_oe = tx_act && swapped;
  assign sck_oe = ctrl.master && (tx_act || rx_act);

  // R11
  shared_no_sdi_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.layout == LAYOUT_SHARED) |-> !sdi_oe);
endmodule

// File: rtl/ssu_sck_gen.sv
module ssu_sck_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic run,
  input  logic sck_i,
  output logic sck_o,
  output logic rise,
  output logic fall
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned SYNC_N = 3;

  logic [DIV_W-1:0]  div_q;
  logic              sck_q;
  logic [SYNC_N-1:0] sync_q;
  logic              wrap;

  assign wrap = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || !master) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-2:0], sck_i};
  end

  always_comb begin
    if (master) begin
      rise = run && wrap && !sck_q;
      fall = run && wrap && sck_q;
    end else begin
      rise = sync_q[SYNC_N-2] && !sync_q[SYNC_N-1];
      fall = !sync_q[SYNC_N-2] && sync_q[SYNC_N-1];
    end
  end

  assign sck_o = sck_q;
endmodule

// File: rtl/ssu_shift_engine.sv
module ssu_shift_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master,
  input  logic         tx_act,
  input  logic         rx_act,
  input  logic         rx_full,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_byte,
  input  logic         rise,
  input  logic         fall,
  input  logic         rx_bit,
  output logic         load_ack,
  output logic         byte_done,
  output logic         rx_strobe,
  output logic [W-1:0] rx_byte,
  output logic         busy,
  output logic         tx_bit
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     txsh_q;
  logic [W-1:0]     rxsh_q;
  logic             arm;
  logic             last;

  assign load_ack  = !busy_q && tx_act && tx_avail;
  assign arm       = !busy_q && !tx_act && rx_act && (!master || !rx_full);
  assign last      = (cnt_q == CNT_W'(W - 1));
  assign rx_byte   = {rxsh_q[W-2:0], rx_bit};
  assign rx_strobe = busy_q && rise && last && rx_act;
  assign byte_done = busy_q && fall && last;
  assign busy      = busy_q;
  assign tx_bit    = txsh_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else if (load_ack) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      txsh_q <= tx_byte;
    end else if (arm) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (!(tx_act || rx_act)) begin
        busy_q <= 1'b0;
      end else begin
        if (rise) rxsh_q <= rx_byte;
        if (fall) begin
          txsh_q <= {txsh_q[W-2:0], 1'b0};
          cnt_q  <= cnt_q + 1'b1;
          if (last) busy_q <= 1'b0;
        end
      end
    end
  end

  // R4
  idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !busy_q);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssu_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              rx_full,
  output logic              rx_ovr,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdo_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              sdi_i,
  output logic              sdi_o,
  output logic              sdi_oe
);
  localparam int unsigned PAD_CTRL = DATA_W - CTRL_W;
  localparam int unsigned PAD_STAT = DATA_W - 4;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] tdr_q;
  logic [DATA_W-1:0] rdr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              txe_q, tend_q, rxf_q, ovr_q;

  logic tx_act, rx_act, rx_from_sdo;
  logic run, rise, fall;
  logic load_ack, byte_done, rx_strobe, busy, tx_bit;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] tx_byte;
  logic wr_ctrl, wr_stat, wr_txd, rd_rxd;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));
  assign wr_stat = wr_en && (addr == ADDR_W'(REG_STAT));
  assign wr_txd  = wr_en && (addr == ADDR_W'(REG_TXD));
  assign rd_rxd  = rd_en && (addr == ADDR_W'(REG_RXD));
  assign tx_byte = wr_txd ? wdata : tdr_q;
  assign run     = busy;

  ssu_pin_map u_pins (
    .clk(clk), .rst(rst), .ctrl(ctrl_q),
    .tx_act(tx_act), .rx_act(rx_act), .rx_from_sdo(rx_from_sdo),
    .sck_oe(sck_oe), .sdo_oe(sdo_oe), .sdi_oe(sdi_oe)
  );

  ssu_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
    .clk(clk), .rst(rst), .master(ctrl_q.master), .run(run),
    .sck_i(sck_i), .sck_o(sck_o), .rise(rise), .fall(fall)
  );

  ssu_shift_engine #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .master(ctrl_q.master),
    .tx_act(tx_act), .rx_act(rx_act), .rx_full(rxf_q),
    .tx_avail(wr_txd || !txe_q), .tx_byte(tx_byte),
    .rise(rise), .fall(fall),
    .rx_bit(rx_from_sdo ? sdo_i : sdi_i),
    .load_ack(load_ack), .byte_done(byte_done), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .busy(busy), .tx_bit(tx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      tdr_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_txd)  tdr_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txe_q  <= 1'b1;
      tend_q <= 1'b1;
    end else begin
      if (load_ack)                      txe_q <= 1'b1;
      else if (wr_txd)                   txe_q <= 1'b0;
      else if (wr_stat && !wdata[ST_TXE]) txe_q <= 1'b0;

      if (wr_txd || load_ack)            tend_q <= 1'b0;
      else if (byte_done && txe_q)       tend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxf_q <= 1'b0;
      ovr_q <= 1'b0;
      rdr_q <= '0;
    end else begin
      if (rx_strobe && !rxf_q) begin
        rxf_q <= 1'b1;
        rdr_q <= rx_byte;
      end else if (rd_rxd) begin
        rxf_q <= 1'b0;
      end
      if (rx_strobe && rxf_q)                ovr_q <= 1'b1;
      else if (wr_stat && !wdata[ST_OVR])    ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(REG_CTRL): rdata_q <= {{PAD_CTRL{1'b0}}, ctrl_q};
        ADDR_W'(REG_STAT): rdata_q <= {{PAD_STAT{1'b0}}, ovr_q, rxf_q, tend_q, txe_q};
        ADDR_W'(REG_TXD):  rdata_q <= tdr_q;
        default:           rdata_q <= rdr_q;
      endcase
    end
  end

  assign rdata    = rdata_q;
  assign tx_empty = txe_q;
  assign tx_end   = tend_q;
  assign rx_full  = rxf_q;
  assign rx_ovr   = ovr_q;
  assign sdo_o    = tx_bit;
  assign sdi_o    = tx_bit;

  // R2
  load_keeps_empty_chk: assert property (@(posedge clk) disable iff (rst)
    load_ack |=> (txe_q && !tend_q));

  // R3
  queued_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_txd && busy) |=> !txe_q);

  // R6
  rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && !rxf_q) |=> rxf_q);

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_strobe && rxf_q) |=> (ovr_q && $stable(rdr_q)));
endmodule

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int NVEC = 13;
  // {control byte, expected {sck_oe, sdo_oe, sdi_oe}}
  localparam logic [10:0] VEC [0:NVEC-1] = '{
    {8'h0C, 3'b110}, {8'h14, 3'b100}, {8'h08, 3'b010}, {8'h10, 3'b000},
    {8'h1D, 3'b110}, {8'h0E, 3'b110}, {8'h0A, 3'b001}, {8'h12, 3'b000},
    {8'h1E, 3'b110}, {8'h0F, 3'b110}, {8'h13, 3'b000}, {8'h1F, 3'b110},
    {8'h04, 3'b000}
  };

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic tx_empty, tx_end, rx_full, rx_ovr;
  logic sck_in = 0, sck_o, sck_oe;
  logic slv_bit = 0, loop_en = 1;
  logic sdo_o, sdo_oe, sdi_o, sdi_oe;
  logic sdo_in, sdi_in;
  int total = 0, bad = 0;
  int cyc = 0, cap_n = 0, gap_last = 0, last_rise = 0;
  logic [31:0] cap_bits = 0;

  assign sdo_in = slv_bit;
  assign sdi_in = loop_en ? sdo_o : ~slv_bit;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_empty(tx_empty), .tx_end(tx_end),
    .rx_full(rx_full), .rx_ovr(rx_ovr), .sck_i(sck_in), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdo_i(sdo_in), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .sdi_i(sdi_in), .sdi_o(sdi_o), .sdi_oe(sdi_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;
  always @(posedge sck_o) begin
    cap_bits = {cap_bits[30:0], sdo_o};
    cap_n = cap_n + 1;
    gap_last = cyc - last_rise;
    last_rise = cyc;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (tx_end !== 1'b0 && t < 50) begin @(negedge clk); t++; end
    t = 0;
    while (tx_end !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    check(req, {31'd0, tx_end}, 32'd1);
  endtask

  task automatic slave_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      slv_bit = b[i]; sck_in = 0;
      repeat (4) @(negedge clk);
      sck_in = 1;
      repeat (4) @(negedge clk);
    end
    sck_in = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {28'd0, rx_ovr, rx_full, tx_end, tx_empty}, 32'h3);
    check("R1 oe", {29'd0, sck_oe, sdo_oe, sdi_oe}, 32'h0);

    // R9 R10 R11 R12 pin decode table
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, VEC[i][10:3]);
      check("R9 R10 R11 R12 pin map", {29'd0, sck_oe, sdo_oe, sdi_oe}, {29'd0, VEC[i][2:0]});
    end

    // R2 R3 R4 R5 master transmit with a queued byte
    wr(2'd0, 8'h0C);
    base = cap_n;
    wr(2'd2, 8'hA5);
    check("R2 empty after idle write", {31'd0, tx_empty}, 32'd1);
    check("R2 end cleared", {31'd0, tx_end}, 32'd0);
    wr(2'd2, 8'h3C);
    check("R3 empty after busy write", {31'd0, tx_empty}, 32'd0);
    while (cap_n < base + 2) @(negedge clk);
    check("R4 sck period", gap_last, 2 * DIV);
    while (cap_n < base + 9) @(negedge clk);
    check("R5 end low between bytes", {31'd0, tx_end}, 32'd0);
    wait_done("R5 end after pair");
    check("R3 bit count", cap_n - base, 16);
    check("R4 msb first pair", {16'd0, cap_bits[15:0]}, 32'hA53C);
    check("R5 empty at end", {31'd0, tx_empty}, 32'd1);

    // R6 loopback receive and read clear
    wr(2'd0, 8'h1C);
    wr(2'd2, 8'h5A);
    wait_done("R6 done");
    check("R6 full set", {31'd0, rx_full}, 32'd1);
    rd(2'd3, d);
    check("R6 data", {24'd0, d}, 32'h5A);
    check("R6 full cleared", {31'd0, rx_full}, 32'd0);

    // R7 overrun keeps older byte
    wr(2'd2, 8'h11);
    wait_done("R7 first");
    wr(2'd2, 8'h22);
    wait_done("R7 second");
    check("R7 overrun set", {31'd0, rx_ovr}, 32'd1);
    rd(2'd3, d);
    check("R7 old byte kept", {24'd0, d}, 32'h11);
    wr(2'd1, 8'hF7);
    check("R7 overrun cleared", {31'd0, rx_ovr}, 32'd0);
    check("R8 bit0 one no effect", {31'd0, tx_empty}, 32'd1);

    // R8 status clear of empty resends held byte
    base = cap_n;
    wr(2'd1, 8'h08);
    wait_done("R8 resend done");
    check("R8 resend count", cap_n - base, 8);
    check("R8 resend data", {24'd0, cap_bits[7:0]}, 32'h22);
    rd(2'd3, d);
    check("R8 resend received", {24'd0, d}, 32'h22);

    // R10 four-wire slave receive reads data-out pin
    loop_en = 0;
    wr(2'd0, 8'h12);
    slave_byte(8'hC3);
    check("R10 slave full", {31'd0, rx_full}, 32'd1);
    rd(2'd3, d);
    check("R10 slave data from sdo", {24'd0, d}, 32'hC3);
    check("R12 slave sck not driven", {31'd0, sck_oe}, 32'd0);

    // R11 shared line with both enables: transmit only
    loop_en = 1;
    wr(2'd0, 8'h1F);
    base = cap_n;
    wr(2'd2, 8'h77);
    wait_done("R11 done");
    check("R11 tx data", {24'd0, cap_bits[7:0]}, 32'h77);
    check("R11 no receive", {31'd0, rx_full}, 32'd0);
    check("R11 sdi idle", {31'd0, sdi_oe}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule